// File: doc/BRIEF.md
# Zero-Wait-State Banked SRAM Bus Slave

This block is an AHB slave that gives a bus master read and write access to an on-chip SRAM. The storage is made of 512-byte banks, added in groups of four, that together form one contiguous linear address region. Byte, halfword and word transfers are supported, and the slave steers the matching byte lanes of the 32-bit data buses.

A small data-phase state machine follows the bus pipeline. It has three states: `ST_IDLE` (no data phase owed), `ST_WDATA` (write data phase, in which write data is committed) and `ST_RDATA` (read data phase, in which read data is driven). On every cycle with `hready_in` high, an accepted transfer moves the machine to `ST_WDATA` (write) or `ST_RDATA` (read). Any cycle without an accepted transfer moves it to `ST_IDLE`. While `hready_in` is low, the state holds.

The slave never inserts wait states and always answers OKAY. The memory is read during the address phase, so read data is ready in the data phase. A read that directly follows a write to the same word is served from a forwarding register, so it returns the bytes just written.

Top module: `ahb_bank_sram`

## Requirements
- R1: While `hresetn` is low, and after it is released, `hrdata` is 0 until the first read data phase. `hready` is always 1, and `hresp` is always 2'b00 (okay).
- R2: A transfer is accepted only when `hsel` is 1, `hready_in` is 1 and `htrans` is 2'b10 (non-sequential) or 2'b11 (sequential). With `htrans` 2'b00 (idle) or 2'b01 (busy), `hsel` 0 or `hready_in` 0, memory is not changed.
- R3: An accepted write (`hwrite`=1) stores `hwdata` at the clock edge that ends its data phase. An accepted read (`hwrite`=0) drives the stored word on `hrdata` in the cycle after its address phase. Transfers may follow each other back to back.
- R4: `hsize`=3'b000 is a byte access. Address bits [1:0] select lane L, and only memory byte L of the word takes `hwdata[8L+7:8L]`.
- R5: `hsize`=3'b001 is a halfword access. Address bit [1] selects lanes {3,2} (bit 1 set) or {1,0} (bit 1 clear).
- R6: An `hsize` of 3'b010 or larger writes all four lanes.
- R7: Each bank holds 512 bytes, and `BANKS` (a multiple of 4, from 4 to 64) gives `BANKS`*512 bytes. Byte address A lies in bank A/512, so consecutive 512-byte regions hold independent data. At most one bank is written per cycle.
- R8: Word index `haddr[14:2]` is taken modulo `BANKS`*128, so addresses at and beyond the memory size alias to the low region.
- R9: A read accepted in the data phase of a write to the same word returns the newly written lanes merged with the unchanged stored lanes.
- R10: `hrdata` is 0 in every cycle that is not a read data phase.
- R11: The state machine moves to `ST_WDATA` after an accepted write, to `ST_RDATA` after an accepted read, and to `ST_IDLE` after a cycle with `hready_in`=1 and no accepted transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock, rising edge |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Slave select from the address decoder |
| haddr | input | 15 | Low 15 bits of the byte address |
| htrans | input | 2 | Transfer type: 00 idle, 01 busy, 10 non-sequential, 11 sequential |
| hwrite | input | 1 | 1 write, 0 read |
| hsize | input | 3 | Transfer size: 000 byte, 001 halfword, 010 word |
| hwdata | input | 32 | Write data, valid in the data phase |
| hready_in | input | 1 | Bus ready, 1 when the previous transfer completes |
| hrdata | output | 32 | Read data, valid in the read data phase |
| hready | output | 1 | Transfer done, always 1 |
| hresp | output | 2 | Response, always 00 (okay) |

## Verification
The bench builds the slave with 12 banks, so the memory is 6144 bytes. This size is not a power of two, so the modulo wrap cannot fall back to plain bit truncation. An address of 0x1810 must alias to 0x0010, and 0x7FFC must alias to 0x07FC. With twelve banks, the bank index uses four bits with unused codes, and writes and reads either side of the 512-byte boundaries and at the last word exercise the bank decode. The back-to-back write-then-read cases reach the forwarding path in all three shapes: a partial write to the same word, a full word write to the same word, and a write to a neighbouring word.

// File: rtl/ahb_sram_pkg.sv
package ahb_sram_pkg;

    // Data-phase state of the slave
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WDATA = 2'd1,
        ST_RDATA = 2'd2
    } dphase_e;

    localparam logic [1:0] TR_IDLE = 2'b00;
    localparam logic [1:0] TR_BUSY = 2'b01;
    localparam logic [1:0] TR_NSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ  = 2'b11;

    localparam logic [1:0] RSP_OKAY = 2'b00;

    localparam int unsigned LANES      = 4;
    localparam int unsigned BANK_BYTES = 512;

endpackage

// File: rtl/ahb_sram_lane_decode.sv
module ahb_sram_lane_decode
    import ahb_sram_pkg::*;
(
    input  logic [2:0]       size,
    input  logic [1:0]       lo,
    output logic [LANES-1:0] be
);

    always_comb begin
        unique case (size)
            3'b000:  be = 4'b0001 << lo;
            3'b001:  be = lo[1] ? 4'b1100 : 4'b0011;
            default: be = 4'b1111;
        endcase
    end

endmodule

// File: rtl/ahb_sram_ctrl.sv
module ahb_sram_ctrl
    import ahb_sram_pkg::*;
#(
    parameter  int unsigned BANKS   = 4,
    parameter  int unsigned ADDR_W  = 15,
    localparam int unsigned WPB     = BANK_BYTES / LANES,
    localparam int unsigned OFF_W   = $clog2(WPB),
    localparam int unsigned BANK_W  = (BANKS > 1) ? $clog2(BANKS) : 1
)(
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic              hready_in,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [ADDR_W-1:0] haddr,
    output dphase_e           state,
    output logic              ap_rd,
    output logic [BANK_W-1:0] ap_bank,
    output logic [OFF_W-1:0]  ap_off,
    output logic              wr_commit,
    output logic              rd_phase,
    output logic [BANK_W-1:0] dp_bank,
    output logic [OFF_W-1:0]  dp_off,
    output logic [LANES-1:0]  dp_be
);

    localparam int unsigned TOTAL_WORDS = BANKS * WPB;
    localparam int unsigned IDX_W       = ADDR_W - 2;
    localparam int unsigned WR_W        = IDX_W + 1;

    dphase_e          state_nx;
    logic             accept;
    logic [WR_W-1:0]  wrapped;
    logic [LANES-1:0] ap_be;

    // Address-phase decode
    always_comb begin
        accept  = hsel && hready_in && htrans[1];
        ap_rd   = accept && !hwrite;
        wrapped = {1'b0, haddr[ADDR_W-1:2]} % WR_W'(TOTAL_WORDS);
        ap_bank = BANK_W'(wrapped >> OFF_W);
        ap_off  = wrapped[OFF_W-1:0];
    end

    ahb_sram_lane_decode u_lanes (
        .size (hsize),
        .lo   (haddr[1:0]),
        .be   (ap_be)
    );

    // State register
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) state <= ST_IDLE;
        else          state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (hready_in) begin
            unique case ({accept, hwrite})
                2'b11:   state_nx = ST_WDATA;
                2'b10:   state_nx = ST_RDATA;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // Outputs per state
    always_comb begin
        wr_commit = 1'b0;
        rd_phase  = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_WDATA: wr_commit = hready_in;
            ST_RDATA: rd_phase  = 1'b1;
            default:  ;
        endcase
    end

    // Address-phase capture for the data phase
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            dp_bank <= '0;
            dp_off  <= '0;
            dp_be   <= '0;
        end else if (accept) begin
            dp_bank <= ap_bank;
            dp_off  <= ap_off;
            dp_be   <= ap_be;
        end
    end

endmodule

// File: rtl/ahb_sram_bank.sv
module ahb_sram_bank
    import ahb_sram_pkg::*;
#(
    parameter  int unsigned WORDS = BANK_BYTES / LANES,
    localparam int unsigned AW    = $clog2(WORDS)
)(
    input  logic                 clk,
    input  logic                 re,
    input  logic [AW-1:0]        raddr,
    output logic [8*LANES-1:0]   rdata,
    input  logic [LANES-1:0]     we,
    input  logic [AW-1:0]        waddr,
    input  logic [8*LANES-1:0]   wdata
);

    logic [8*LANES-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        for (int l = 0; l < int'(LANES); l++) begin
            if (we[l]) mem[waddr][8*l +: 8] <= wdata[8*l +: 8];
        end
        if (re) rdata <= mem[raddr];
    end

endmodule

// File: rtl/ahb_bank_sram.sv
module ahb_bank_sram
    import ahb_sram_pkg::*;
#(
    parameter  int unsigned BANKS  = 4,
    localparam int unsigned ADDR_W = 15,
    localparam int unsigned DW     = 8 * LANES
)(
    input  logic              hclk,
    input  logic              hresetn,
    input  logic              hsel,
    input  logic [ADDR_W-1:0] haddr,
    input  logic [1:0]        htrans,
    input  logic              hwrite,
    input  logic [2:0]        hsize,
    input  logic [DW-1:0]     hwdata,
    input  logic              hready_in,
    output logic [DW-1:0]     hrdata,
    output logic              hready,
    output logic [1:0]        hresp
);

    localparam int unsigned WPB    = BANK_BYTES / LANES;
    localparam int unsigned OFF_W  = $clog2(WPB);
    localparam int unsigned BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;

    dphase_e           state;
    logic              ap_rd, wr_commit, rd_phase;
    logic [BANK_W-1:0] ap_bank, dp_bank, rd_bank_q;
    logic [OFF_W-1:0]  ap_off, dp_off;
    logic [LANES-1:0]  dp_be, fwd_be;
    logic [DW-1:0]     fwd_data;
    logic [DW-1:0]     bank_rd [BANKS];
    logic [LANES-1:0]  bank_we [BANKS];
    logic [BANKS-1:0]  bank_wr_any;

    ahb_sram_ctrl #(.BANKS(BANKS), .ADDR_W(ADDR_W)) u_ctrl (
        .hclk      (hclk),
        .hresetn   (hresetn),
        .hsel      (hsel),
        .hready_in (hready_in),
        .htrans    (htrans),
        .hwrite    (hwrite),
        .hsize     (hsize),
        .haddr     (haddr),
        .state     (state),
        .ap_rd     (ap_rd),
        .ap_bank   (ap_bank),
        .ap_off    (ap_off),
        .wr_commit (wr_commit),
        .rd_phase  (rd_phase),
        .dp_bank   (dp_bank),
        .dp_off    (dp_off),
        .dp_be     (dp_be)
    );

    for (genvar b = 0; b < int'(BANKS); b++) begin : g_bank
        logic hit_w, hit_r;
        assign hit_w          = wr_commit && (dp_bank == BANK_W'(b));
        assign hit_r          = ap_rd && (ap_bank == BANK_W'(b));
        assign bank_we[b]     = hit_w ? dp_be : '0;
        assign bank_wr_any[b] = |bank_we[b];

        ahb_sram_bank #(.WORDS(WPB)) u_bank (
            .clk   (hclk),
            .re    (hit_r),
            .raddr (ap_off),
            .rdata (bank_rd[b]),
            .we    (bank_we[b]),
            .waddr (dp_off),
            .wdata (hwdata)
        );
    end

    // Read bank index and same-word forwarding capture
    always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn) begin
            rd_bank_q <= '0;
            fwd_be    <= '0;
            fwd_data  <= '0;
        end else if (hready_in) begin
            if (ap_rd) rd_bank_q <= ap_bank;
            fwd_be   <= (wr_commit && ap_rd && ap_bank == dp_bank && ap_off == dp_off)
                        ? dp_be : '0;
            fwd_data <= hwdata;
        end
    end

    always_comb begin
        hrdata = '0;
        if (rd_phase) begin
            for (int l = 0; l < int'(LANES); l++) begin
                hrdata[8*l +: 8] = fwd_be[l] ? fwd_data[8*l +: 8]
                                             : bank_rd[rd_bank_q][8*l +: 8];
            end
        end
    end

    assign hready = 1'b1;
    assign hresp  = RSP_OKAY;

endmodule

// File: rtl/ahb_sram_chk.sv
module ahb_sram_chk
    import ahb_sram_pkg::*;
#(
    parameter int unsigned BANKS = 4
)(
    input logic             hclk,
    input logic             hresetn,
    input logic             hsel,
    input logic             hready_in,
    input logic [1:0]       htrans,
    input logic             hwrite,
    input logic [31:0]      hrdata,
    input dphase_e          state,
    input logic [BANKS-1:0] bank_wr_any
);

    // R11
    wr_accept_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsel && hready_in && htrans[1] && hwrite) |=> (state == ST_WDATA));

    // R11
    rd_accept_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hsel && hready_in && htrans[1] && !hwrite) |=> (state == ST_RDATA));

    // R2
    no_accept_idle_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (hready_in && !(hsel && htrans[1])) |=> (state == ST_IDLE));

    // R2
    wr_only_dphase_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (|bank_wr_any) |-> (state == ST_WDATA && hready_in));

    // R7
    one_bank_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        $onehot0(bank_wr_any));

    // R10
    rdata_quiet_chk: assert property (@(posedge hclk) disable iff (!hresetn)
        (state != ST_RDATA) |-> (hrdata == 32'd0));

endmodule

bind ahb_bank_sram ahb_sram_chk #(.BANKS(BANKS)) u_chk (
    .hclk        (hclk),
    .hresetn     (hresetn),
    .hsel        (hsel),
    .hready_in   (hready_in),
    .htrans      (htrans),
    .hwrite      (hwrite),
    .hrdata      (hrdata),
    .state       (state),
    .bank_wr_any (bank_wr_any)
);

// File: tb/tb_ahb_bank_sram.sv
`timescale 1ns/1ps
module tb_ahb_bank_sram;

    localparam int BANKS     = 12;
    localparam int MEM_BYTES = BANKS * 512;
    localparam int WORDS     = MEM_BYTES / 4;

    logic        hclk = 1'b0;
    logic        hresetn = 1'b0;
    logic        hsel = 1'b0;
    logic [14:0] haddr = '0;
    logic [1:0]  htrans = 2'b00;
    logic        hwrite = 1'b0;
    logic [2:0]  hsize = 3'b010;
    logic [31:0] hwdata = '0;
    logic        hready_in = 1'b1;
    logic [31:0] hrdata;
    logic        hready;
    logic [1:0]  hresp;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [7:0] ref_mem [MEM_BYTES];

    always #5 hclk = ~hclk;

    ahb_bank_sram #(.BANKS(BANKS)) dut (
        .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .haddr(haddr),
        .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata),
        .hready_in(hready_in), .hrdata(hrdata), .hready(hready), .hresp(hresp)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int base_of(input logic [14:0] a);
        return ((int'(a) >> 2) % WORDS) * 4;
    endfunction

    function automatic logic [31:0] model_word(input logic [14:0] a);
        int b = base_of(a);
        return {ref_mem[b+3], ref_mem[b+2], ref_mem[b+1], ref_mem[b]};
    endfunction

    task automatic model_write(input logic [14:0] a, input logic [2:0] sz, input logic [31:0] d);
        int b = base_of(a);
        for (int l = 0; l < 4; l++) begin
            bit en;
            if (sz == 3'b000)      en = (l == int'(a[1:0]));
            else if (sz == 3'b001) en = ((l / 2) == int'(a[1]));
            else                   en = 1'b1;
            if (en) ref_mem[b+l] = d[8*l +: 8];
        end
    endtask

    task automatic drive(input logic s, input logic [1:0] t, input logic w,
                         input logic [2:0] sz, input logic [14:0] a, input logic rdy);
        hsel = s; htrans = t; hwrite = w; hsize = sz; haddr = a; hready_in = rdy;
    endtask

    task automatic go_idle();
        drive(1'b0, 2'b00, 1'b0, 3'b010, 15'h0, 1'b1);
    endtask

    task automatic do_write(input logic [14:0] a, input logic [2:0] sz, input logic [31:0] d);
        @(negedge hclk); drive(1'b1, 2'b10, 1'b1, sz, a, 1'b1);
        @(negedge hclk); go_idle(); hwdata = d; model_write(a, sz, d);
        @(negedge hclk);
    endtask

    task automatic do_read(input logic [14:0] a, output logic [31:0] d);
        @(negedge hclk); drive(1'b1, 2'b10, 1'b0, 3'b010, a, 1'b1);
        @(negedge hclk); go_idle(); d = hrdata;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge hclk);
        check("R1 hrdata in reset", hrdata, 32'h0);
        check("R1 hready in reset", {31'b0, hready}, 32'h1);
        check("R1 hresp in reset", {30'b0, hresp}, 32'h0);
        hresetn = 1'b1;
        @(negedge hclk);
        check("R1 hrdata after reset", hrdata, 32'h0);
    endtask

    task automatic t_word_banks();
        logic [31:0] d;
        logic [14:0] addrs [5] = '{15'h0000, 15'h01FC, 15'h0200, 15'h0400, 15'h17FC};
        foreach (addrs[i]) do_write(addrs[i], 3'b010, 32'hA5000000 + 32'(i * 32'h01010101));
        foreach (addrs[i]) begin
            do_read(addrs[i], d);
            check($sformatf("R3 R7 word at %h", addrs[i]), d, model_word(addrs[i]));
        end
    endtask

    task automatic t_byte_lanes();
        logic [31:0] d;
        do_write(15'h0040, 3'b010, 32'h11223344);
        for (int l = 0; l < 4; l++) begin
            logic [31:0] w = 32'hEEEEEEEE;
            w[8*l +: 8] = 8'hA0 + 8'(l);
            do_write(15'h0040 + 15'(l), 3'b000, w);
            do_read(15'h0040, d);
            check($sformatf("R4 byte lane %0d", l), d, model_word(15'h0040));
        end
        check("R4 final bytes", d, 32'hA3A2A1A0);
    endtask

    task automatic t_half();
        logic [31:0] d;
        do_write(15'h0080, 3'b010, 32'h55667788);
        do_write(15'h0082, 3'b001, 32'hBEEFCAFE);
        do_read(15'h0080, d);
        check("R5 upper halfword", d, 32'hBEEF7788);
        do_write(15'h0080, 3'b001, 32'h1234ABCD);
        do_read(15'h0080, d);
        check("R5 lower halfword", d, 32'hBEEFABCD);
    endtask

    task automatic t_size_word();
        logic [31:0] d;
        do_write(15'h0091, 3'b010, 32'hCAFEF00D);
        do_read(15'h0090, d);
        check("R6 size 010", d, 32'hCAFEF00D);
        do_write(15'h0090, 3'b011, 32'h0BADBEEF);
        do_read(15'h0090, d);
        check("R6 size 011 as word", d, 32'h0BADBEEF);
    endtask

    task automatic t_ignored();
        logic [31:0] d;
        do_write(15'h00A0, 3'b010, 32'h13579BDF);
        // idle, busy, deselected, bus not ready: each with write intent
        @(negedge hclk); drive(1'b1, 2'b00, 1'b1, 3'b010, 15'h00A0, 1'b1);
        @(negedge hclk); drive(1'b1, 2'b01, 1'b1, 3'b010, 15'h00A0, 1'b1); hwdata = 32'hDEADBEEF;
        @(negedge hclk); drive(1'b0, 2'b10, 1'b1, 3'b010, 15'h00A0, 1'b1); hwdata = 32'hDEADBEEF;
        @(negedge hclk); drive(1'b1, 2'b10, 1'b1, 3'b010, 15'h00A0, 1'b0); hwdata = 32'hDEADBEEF;
        @(negedge hclk); go_idle(); hwdata = 32'hDEADBEEF;
        @(negedge hclk);
        do_read(15'h00A0, d);
        check("R2 ignored transfers keep data", d, 32'h13579BDF);
        @(negedge hclk); drive(1'b0, 2'b10, 1'b0, 3'b010, 15'h00A0, 1'b1);
        @(negedge hclk); go_idle();
        check("R2 R10 deselected read gives zero", hrdata, 32'h0);
    endtask

    task automatic t_wrap();
        logic [31:0] d;
        do_write(15'h1810, 3'b010, 32'h0F1E2D3C);
        do_read(15'h0010, d);
        check("R8 wrap 0x1810 to 0x0010", d, 32'h0F1E2D3C);
        do_write(15'h7FFC, 3'b010, 32'h89ABCDEF);
        do_read(15'h07FC, d);
        check("R8 wrap 0x7FFC to 0x07FC", d, 32'h89ABCDEF);
        check("R8 model agrees", d, model_word(15'h7FFC));
    endtask

    task automatic t_fwd();
        logic [31:0] w;
        do_write(15'h00C0, 3'b010, 32'h01020304);
        do_write(15'h00C4, 3'b010, 32'h0A0B0C0D);
        // byte write then read same word back to back
        @(negedge hclk); drive(1'b1, 2'b10, 1'b1, 3'b000, 15'h00C1, 1'b1);
        @(negedge hclk); drive(1'b1, 2'b11, 1'b0, 3'b010, 15'h00C0, 1'b1);
        w = 32'hEEEE99EE; hwdata = w; model_write(15'h00C1, 3'b000, w);
        @(negedge hclk); go_idle();
        check("R9 byte forward", hrdata, 32'h01029904);
        // full word write then read same word
        @(negedge hclk); drive(1'b1, 2'b10, 1'b1, 3'b010, 15'h00C0, 1'b1);
        @(negedge hclk); drive(1'b1, 2'b11, 1'b0, 3'b010, 15'h00C0, 1'b1);
        hwdata = 32'h77665544; model_write(15'h00C0, 3'b010, 32'h77665544);
        @(negedge hclk); go_idle();
        check("R9 word forward", hrdata, 32'h77665544);
        // write to neighbour then read: no forwarding
        @(negedge hclk); drive(1'b1, 2'b10, 1'b1, 3'b010, 15'h00C4, 1'b1);
        @(negedge hclk); drive(1'b1, 2'b11, 1'b0, 3'b010, 15'h00C0, 1'b1);
        hwdata = 32'hFFFFFFFF; model_write(15'h00C4, 3'b010, 32'hFFFFFFFF);
        @(negedge hclk); go_idle();
        check("R9 neighbour not forwarded", hrdata, 32'h77665544);
    endtask

    task automatic t_pipe_reads();
        @(negedge hclk); drive(1'b1, 2'b10, 1'b0, 3'b010, 15'h0000, 1'b1);
        @(negedge hclk); drive(1'b1, 2'b11, 1'b0, 3'b010, 15'h0200, 1'b1);
        check("R3 R11 first pipelined read", hrdata, model_word(15'h0000));
        @(negedge hclk); go_idle();
        check("R3 R11 second pipelined read", hrdata, model_word(15'h0200));
        @(negedge hclk);
        check("R10 R11 idle after reads", hrdata, 32'h0);
        check("R1 hready/hresp steady", {29'b0, hready, hresp}, 32'h4);
    endtask

    initial begin
        t_reset();
        t_word_banks();
        t_byte_lanes();
        t_half();
        t_size_word();
        t_ignored();
        t_wrap();
        t_fwd();
        t_pipe_reads();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge hclk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule